// File: doc/BRIEF.md
# Fault-Mode Switch Commutation Sequencer

This block owns the gate drive of a six-switch bridge and of two auxiliary switches. In normal operation it passes a gate vector from the current regulator straight through. When a fault flag rises, it takes over the gates. It moves the bridge through a staged commutation that keeps the capacitor out of the fault current path. When the flag falls, it hands the gates back through a controlled return sequence.

Two strategies can be selected, and the choice is latched when a sequence begins. In the bypass strategy, two bidirectional auxiliary switches (gate bits 6 and 7) form a parallel branch that takes over the current. In the series strategy, auxiliary switch 7 (gate bit 6) sits in series with the capacitor. It is held closed in normal operation and opened once the capacitor current has been reported as zero. A programmable dead time separates every turn-off from the next turn-on. The current step is reported as a 3-bit stage code.

Gate bit k drives switch k+1. Bridge switches 1, 3 and 5 are bits 0, 2 and 4. Switches 2, 4 and 6 are bits 1, 3 and 5. Every duration below written as ⌈N⌉ means N cycles, or 1 cycle when N is 0.

Top module: `fm_commut_seq`

## Requirements
- R1: At stage 0 (normal), gate bits 5..0 equal `norm_gate_i`. Bit 7 is 0. Bit 6 is 0 when `strat_i` is 0 (bypass) and 1 when `strat_i` is 1 (series).
- R2: A high `fault_i` at stage 0 leads to stage 1 on the next cycle. For ⌈dead⌉ cycles, bits 1, 3 and 5 are 0, bits 0, 2 and 4 keep their values from the last normal cycle, and the auxiliary bits keep their normal values. After that, bits 0, 2 and 4 are all 1.
- R3: Bypass. Once bits 0, 2 and 4 have been set for ⌈dly_bc⌉ cycles, stage 2 closes bits 6 and 7. After ⌈dly_cd⌉ cycles, stage 3 holds bits 5..0 at 0 and bits 7..6 at 1.
- R4: Series. With bits 0, 2 and 4 set, the block waits for `izero_i`. On the following cycle it enters stage 2 and opens bit 6. After ⌈dead⌉ cycles, stage 3 sets all of bits 5..0 with bit 6 still open.
- R5: `izero_i` has no effect outside the stage-1 wait that follows the turn-off interval.
- R6: If `izero_i` is not seen within ⌈tmo⌉ cycles of waiting, the block enters stage 2 anyway and sets `err_o`. `err_o` stays set until reset.
- R7: In stages 1 to 4, no gate bit rises in the same cycle as a fall, or within ⌈dead⌉ cycles after one.
- R8: Stage 3 ends once `fault_i` is low and at least ⌈dead⌉ cycles have passed in stage 3. Stage 4 first drives bits 5..0 from `norm_gate_i` while keeping the stage-3 auxiliary bits, for ⌈dead⌉ cycles. It then restores the normal auxiliary bits for ⌈dead⌉ cycles, and then stage 0 follows.
- R9: If `fault_i` falls before stage 3, the sequence still runs through stages 2 and 3 before the return.
- R10: Changes of `strat_i` during a sequence have no effect before stage 0 is reached again.
- R11: The stage code is 0 for normal, 1 to 3 for the three commutation steps, and 4 for the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Fault-mode request |
| strat_i | input | 1 | Strategy: 0 bypass pair, 1 series switch |
| norm_gate_i | input | 6 | Normal-mode bridge gate vector |
| izero_i | input | 1 | Capacitor current has reached zero |
| dead_i | input | CNT_W | Dead time in cycles |
| dly_bc_i | input | CNT_W | Bypass: stage 1 on-time before the branch closes |
| dly_cd_i | input | CNT_W | Bypass: stage 2 length |
| tmo_i | input | CNT_W | Series: zero-current wait limit |
| gate_o | output | 8 | Gate vector, bit k drives switch k+1 |
| stage_o | output | 3 | Stage code |
| err_o | output | 1 | Sticky zero-current timeout flag |

## Verification
The bench measures the exact length of every gate segment. A sequencer that miscounts a delay, skips the dead interval or merges the turn-off and turn-on steps shows up as a segment one cycle short or long. The minimum-delay case, with every delay at zero, catches designs that treat zero as "no wait" or as an underflowed full count.

A fault flag that drops in the first cycle, and another that drops during the zero-current wait, catch designs that abort early and leave the capacitor path open. A zero-current indication held high through the turn-off interval catches a design that looks at it too soon. A strategy toggle in mid-sequence catches a design that reads the live select. The timeout run checks that the error flag appears exactly at the forced stage 2 and survives the return.

// File: rtl/fm_seq_pkg.sv
package fm_seq_pkg;

  localparam int NBR = 6;
  localparam int NGT = 8;

  localparam logic [NBR-1:0] ODD_SW  = 6'b010101;
  localparam logic [NBR-1:0] EVEN_SW = 6'b101010;

  localparam logic [2:0] STG_NORM = 3'd0;
  localparam logic [2:0] STG_B    = 3'd1;
  localparam logic [2:0] STG_C    = 3'd2;
  localparam logic [2:0] STG_D    = 3'd3;
  localparam logic [2:0] STG_RET  = 3'd4;

  typedef enum logic [2:0] {
    ST_NORM, ST_BOFF, ST_BON, ST_C, ST_D, ST_RA, ST_RB
  } seq_st_e;

  function automatic int unsigned min_span(input int unsigned lim);
    return (lim == 0) ? 1 : lim;
  endfunction

  function automatic logic span_done(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic logic [1:0] aux_rest(input logic series);
    return series ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] aux_fault(input logic series);
    return series ? 2'b00 : 2'b11;
  endfunction

endpackage

// File: rtl/fm_phase_timer.sv
module fm_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart_i)    cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fm_seq_ctrl.sv
module fm_seq_ctrl
  import fm_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             strat_i,
  input  logic [NBR-1:0]   norm_i,
  input  logic             izero_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] dly_bc_i,
  input  logic [CNT_W-1:0] dly_cd_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic [CNT_W-1:0] span_i,
  output seq_st_e          st_o,
  output logic             mode_o,
  output logic [NBR-1:0]   hold_o,
  output logic             err_o,
  output logic             restart_o
);
  seq_st_e        st_q, st_n;
  logic           mode_q;
  logic [NBR-1:0] hold_q;
  logic           err_q;

  // named events
  logic dead_done, zero_evt, tmo_evt;
  assign dead_done = span_done(32'(span_i), 32'(dead_i));
  assign zero_evt  = (st_q == ST_BON) && mode_q && izero_i;
  assign tmo_evt   = (st_q == ST_BON) && mode_q && !izero_i
                     && span_done(32'(span_i), 32'(tmo_i));

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_NORM: if (fault_i) st_n = ST_BOFF;
      ST_BOFF: if (dead_done) st_n = ST_BON;
      ST_BON: begin
        if (mode_q) begin
          if (zero_evt || tmo_evt) st_n = ST_C;
        end else if (span_done(32'(span_i), 32'(dly_bc_i))) begin
          st_n = ST_C;
        end
      end
      ST_C: begin
        if (mode_q ? dead_done : span_done(32'(span_i), 32'(dly_cd_i)))
          st_n = ST_D;
      end
      ST_D:  if (!fault_i && dead_done) st_n = ST_RA;
      ST_RA: if (dead_done) st_n = ST_RB;
      ST_RB: if (dead_done) st_n = ST_NORM;
      default: st_n = ST_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_NORM;
      mode_q <= 1'b0;
      hold_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_NORM && fault_i) begin
        mode_q <= strat_i;
        hold_q <= norm_i & ODD_SW;
      end
      if (tmo_evt) err_q <= 1'b1;
    end
  end

  assign st_o      = st_q;
  assign mode_o    = mode_q;
  assign hold_o    = hold_q;
  assign err_o     = err_q;
  assign restart_o = (st_n != st_q);
endmodule

// File: rtl/fm_gate_map.sv
module fm_gate_map
  import fm_seq_pkg::*;
(
  input  seq_st_e        st_i,
  input  logic           mode_i,
  input  logic           strat_i,
  input  logic [NBR-1:0] norm_i,
  input  logic [NBR-1:0] hold_i,
  output logic [NGT-1:0] gate_o,
  output logic [2:0]     stage_o
);
  always_comb begin
    gate_o  = {aux_rest(strat_i), norm_i};
    stage_o = STG_NORM;
    unique case (st_i)
      ST_NORM: begin
        gate_o  = {aux_rest(strat_i), norm_i};
        stage_o = STG_NORM;
      end
      ST_BOFF: begin
        gate_o  = {aux_rest(mode_i), hold_i & ODD_SW};
        stage_o = STG_B;
      end
      ST_BON: begin
        gate_o  = {aux_rest(mode_i), ODD_SW};
        stage_o = STG_B;
      end
      ST_C: begin
        gate_o  = {aux_fault(mode_i), ODD_SW};
        stage_o = STG_C;
      end
      ST_D: begin
        gate_o  = {aux_fault(mode_i), mode_i ? {NBR{1'b1}} : {NBR{1'b0}}};
        stage_o = STG_D;
      end
      ST_RA: begin
        gate_o  = {aux_fault(mode_i), norm_i};
        stage_o = STG_RET;
      end
      ST_RB: begin
        gate_o  = {aux_rest(mode_i), norm_i};
        stage_o = STG_RET;
      end
      default: begin
        gate_o  = {aux_rest(strat_i), norm_i};
        stage_o = STG_NORM;
      end
    endcase
  end
endmodule

// File: rtl/fm_commut_seq.sv
module fm_commut_seq
  import fm_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             strat_i,
  input  logic [5:0]       norm_gate_i,
  input  logic             izero_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] dly_bc_i,
  input  logic [CNT_W-1:0] dly_cd_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic [7:0]       gate_o,
  output logic [2:0]       stage_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};

  seq_st_e          st_w;
  logic             mode_w;
  logic [NBR-1:0]   hold_w;
  logic             restart_w;
  logic [CNT_W-1:0] span_w;

  fm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_w), .cnt_o(span_w)
  );

  fm_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .strat_i(strat_i),
    .norm_i(norm_gate_i), .izero_i(izero_i), .dead_i(dead_i),
    .dly_bc_i(dly_bc_i), .dly_cd_i(dly_cd_i), .tmo_i(tmo_i),
    .span_i(span_w), .st_o(st_w), .mode_o(mode_w), .hold_o(hold_w),
    .err_o(err_o), .restart_o(restart_w)
  );

  fm_gate_map u_map (
    .st_i(st_w), .mode_i(mode_w), .strat_i(strat_i), .norm_i(norm_gate_i),
    .hold_i(hold_w), .gate_o(gate_o), .stage_o(stage_o)
  );

  // edge watch on the gate vector, for the dead-time property
  logic [7:0]       prev_g;
  logic [CNT_W-1:0] gap_q;
  logic             fall_now, rise_now;
  assign fall_now = |(prev_g & ~gate_o);
  assign rise_now = |(~prev_g & gate_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_g <= '0;
      gap_q  <= GAP_MAX;
    end else begin
      prev_g <= gate_o;
      if (fall_now)             gap_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && stage_o != STG_NORM) |->
      (!fall_now && 32'(gap_q) >= min_span(32'(dead_i))));

  p_entry_evens_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage_o) == STG_NORM && stage_o == STG_B) |->
      ((gate_o[5:0] & EVEN_SW) == '0 &&
       gate_o[5:0] == ($past(gate_o[5:0]) & ODD_SW)));

  p_bypass_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_w && stage_o == STG_D) |-> (gate_o == 8'hC0));

  p_sw7_open_at_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o[6]) && mode_w && stage_o != STG_NORM) |->
      ($past(stage_o) == STG_B && stage_o == STG_C));

  p_no_zero_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_o == STG_C && $past(stage_o) == STG_B && $past(mode_w) && !$past(izero_i))
      |-> err_o);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> err_o);

  p_b_to_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage_o) == STG_B && stage_o != STG_B) |-> (stage_o == STG_C));

  p_ret_before_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stage_o) != STG_NORM && stage_o == STG_NORM) |-> ($past(stage_o) == STG_RET));

endmodule

// File: tb/fm_commut_seq_test.sv
module fm_commut_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fault_i = 1'b0;
  logic       strat_i = 1'b0;
  logic [5:0] norm_gate_i = 6'h19;
  logic       izero_i = 1'b0;
  logic [7:0] dead_i = 8'd2, dly_bc_i = 8'd3, dly_cd_i = 8'd2, tmo_i = 8'd20;
  logic [7:0] gate_o;
  logic [2:0] stage_o;
  logic       err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fm_commut_seq #(.CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .strat_i(strat_i),
    .norm_gate_i(norm_gate_i), .izero_i(izero_i), .dead_i(dead_i),
    .dly_bc_i(dly_bc_i), .dly_cd_i(dly_cd_i), .tmo_i(tmo_i),
    .gate_o(gate_o), .stage_o(stage_o), .err_o(err_o)
  );

  // checks len consecutive samples (one per falling edge) against one expected segment
  task automatic expect_seg(input logic [2:0] stg, input logic [7:0] g, input int len,
                            input logic e, input string tag);
    logic       bad = 1'b0;
    logic [2:0] a_s = '0;
    logic [7:0] a_g = '0;
    logic       a_e = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (!bad && (stage_o !== stg || gate_o !== g || err_o !== e)) begin
        bad = 1'b1; a_s = stage_o; a_g = gate_o; a_e = err_o;
      end
    end
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: stage/gate/err actual %0d/%h/%0d expected %0d/%h/%0d",
               tag, a_s, a_g, a_e, stg, g, e);
    end
  endtask

  task automatic t_reset;
    norm_gate_i = 6'h19; strat_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_seg(3'd0, 8'h19, 2, 1'b0, "R1 R11 reset bypass");
    strat_i = 1'b1;
    expect_seg(3'd0, 8'h59, 1, 1'b0, "R1 series normal sw7 closed");
    strat_i = 1'b0;
    expect_seg(3'd0, 8'h19, 1, 1'b0, "R1 back to bypass");
  endtask

  task automatic t_bypass;
    dead_i = 8'd2; dly_bc_i = 8'd3; dly_cd_i = 8'd2; norm_gate_i = 6'h19;
    fault_i = 1'b1;
    expect_seg(3'd1, 8'h11, 2, 1'b0, "R2 R7 evens off, odds held");
    expect_seg(3'd1, 8'h15, 3, 1'b0, "R2 R3 odds on for dly_bc");
    strat_i = 1'b1;
    expect_seg(3'd2, 8'hD5, 2, 1'b0, "R3 R10 bypass pair closed");
    expect_seg(3'd3, 8'hC0, 4, 1'b0, "R3 R10 bridge open");
    fault_i = 1'b0; strat_i = 1'b0;
    expect_seg(3'd4, 8'hD9, 2, 1'b0, "R8 return bridge first");
    expect_seg(3'd4, 8'h19, 2, 1'b0, "R8 return aux released");
    expect_seg(3'd0, 8'h19, 2, 1'b0, "R1 R8 normal again");
  endtask

  task automatic t_bypass_min;
    dead_i = 8'd0; dly_bc_i = 8'd0; dly_cd_i = 8'd0; norm_gate_i = 6'h02;
    fault_i = 1'b1;
    expect_seg(3'd1, 8'h00, 1, 1'b0, "R2 R7 zero dead time");
    fault_i = 1'b0;
    expect_seg(3'd1, 8'h15, 1, 1'b0, "R9 continues after early clear");
    expect_seg(3'd2, 8'hD5, 1, 1'b0, "R9 stage C reached");
    expect_seg(3'd3, 8'hC0, 1, 1'b0, "R9 stage D reached");
    expect_seg(3'd4, 8'hC2, 1, 1'b0, "R8 min return A");
    expect_seg(3'd4, 8'h02, 1, 1'b0, "R8 min return B");
    expect_seg(3'd0, 8'h02, 1, 1'b0, "R1 min normal");
  endtask

  task automatic t_series_fast;
    dead_i = 8'd2; tmo_i = 8'd20; strat_i = 1'b1; norm_gate_i = 6'h26;
    izero_i = 1'b1;
    fault_i = 1'b1;
    expect_seg(3'd1, 8'h44, 2, 1'b0, "R5 zero flag ignored while turning off");
    expect_seg(3'd1, 8'h55, 1, 1'b0, "R4 zero seen at once");
    expect_seg(3'd2, 8'h15, 2, 1'b0, "R4 R7 sw7 open");
    izero_i = 1'b0;
    expect_seg(3'd3, 8'h3F, 3, 1'b0, "R4 all bridge closed");
    fault_i = 1'b0;
    expect_seg(3'd4, 8'h26, 2, 1'b0, "R8 series return A");
    expect_seg(3'd4, 8'h66, 2, 1'b0, "R8 sw7 reclosed");
    expect_seg(3'd0, 8'h66, 1, 1'b0, "R1 series normal");
  endtask

  task automatic t_series_wait;
    izero_i = 1'b0;
    fault_i = 1'b1;
    expect_seg(3'd1, 8'h44, 2, 1'b0, "R2 series turn-off");
    expect_seg(3'd1, 8'h55, 5, 1'b0, "R4 waiting for zero current");
    izero_i = 1'b1;
    expect_seg(3'd2, 8'h15, 2, 1'b0, "R4 opens after zero");
    izero_i = 1'b0;
    expect_seg(3'd3, 8'h3F, 2, 1'b0, "R4 stage D");
    fault_i = 1'b0;
    expect_seg(3'd4, 8'h26, 2, 1'b0, "R8 return A");
    expect_seg(3'd4, 8'h66, 2, 1'b0, "R8 return B");
    expect_seg(3'd0, 8'h66, 1, 1'b0, "R1 normal");
  endtask

  task automatic t_series_timeout;
    tmo_i = 8'd4; izero_i = 1'b0;
    fault_i = 1'b1;
    expect_seg(3'd1, 8'h44, 2, 1'b0, "R6 turn-off");
    expect_seg(3'd1, 8'h55, 2, 1'b0, "R6 wait part 1");
    fault_i = 1'b0;
    expect_seg(3'd1, 8'h55, 2, 1'b0, "R6 R9 wait part 2");
    expect_seg(3'd2, 8'h15, 2, 1'b1, "R6 forced stage C with error");
    expect_seg(3'd3, 8'h3F, 2, 1'b1, "R9 stage D before return");
    expect_seg(3'd4, 8'h26, 2, 1'b1, "R8 return A");
    expect_seg(3'd4, 8'h66, 2, 1'b1, "R8 return B");
    expect_seg(3'd0, 8'h66, 2, 1'b1, "R6 error sticky");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    expect_seg(3'd0, 8'h66, 1, 1'b0, "R6 reset clears error");
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_bypass_min();
    t_series_fast();
    t_series_wait();
    t_series_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule